// File: doc/BRIEF.md
# Translation Fault Capture Unit

This block keeps the record of the most recent address-translation failure. A translation unit presents a fault as a one-cycle event that carries the table level where the walk stopped, the kind of failure, a three-bit access index (what sort of access it was and at which privilege) and the virtual address. The block merges these into a ten-bit status word and latches the page-aligned address. If an earlier fault was still sitting in the status word, unread, the old contents are reduced to a lone overflow marker before the new fault is merged in.

On the same event the block decides what the processor should do next. With the no-fault control on, or with traps disabled, no trap is raised and the access gets full permission. Otherwise an instruction fetch raises an instruction-fault trap and any other access raises a data-fault trap. Each of these outcomes is a one-cycle pulse, registered one cycle after the event.

Software reads both registers through one read port. A read of the status word returns its value and clears it at the same edge. A read of the address register has no side effects. Fault events carry no back-pressure: the block takes one on every cycle that `flt_valid` is high, so a source never waits. The read port is plain: `rd_data` follows `rd_sel` in the same cycle.

Top module: `fault_capture_unit`

## Requirements
- R1: After reset the status word, the address register and all three outcome pulses are zero.
- R2: A fault accepted while the status word is zero leaves it holding level in bits 9:8, access index in bits 7:5, fault kind in bits 4:2, bit 1 set (address valid) and bit 0 clear.
- R3: A fault accepted while the status word is nonzero and not being read leaves it holding the R2 value of the new fault with bit 0 (overflow) set as well; no field of the earlier fault survives.
- R4: Each accepted fault loads the address register with its virtual address, with the low PAGE_BITS bits forced to zero.
- R5: A status read (rd_en high, rd_sel 0) returns the current status word on rd_data in that cycle, and the word is zero from the next cycle on.
- R6: A fault accepted in the same cycle as a status read is captured as a fresh fault: the R2 value, with bit 0 clear.
- R7: An address read (rd_en high, rd_sel 1) returns the address register and changes neither register.
- R8: With the no-fault control off and traps enabled, a fetch fault pulses trap_ifetch and any other fault pulses trap_data, for one cycle, one cycle after the event.
- R9: With the no-fault control on or traps disabled, a fault pulses grant_full for one cycle, one cycle after the event, and raises neither trap.
- R10: At most one of trap_ifetch, trap_data and grant_full is high in any cycle, and all three are low in the cycle after one without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | A fault is presented this cycle; always accepted |
| flt_fetch | input | 1 | The faulting access was an instruction fetch |
| flt_level | input | 2 | Table level where the walk stopped |
| flt_kind | input | 3 | Failure kind code |
| flt_acc_idx | input | 3 | Access index (type and privilege of the access) |
| flt_vaddr | input | VA_W | Faulting virtual address |
| ctl_no_fault | input | 1 | No-fault mode: suppress traps |
| ctl_traps_en | input | 1 | Processor traps enabled |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects status word, 1 selects address register |
| rd_data | output | VA_W | Read data, status zero-extended |
| trap_ifetch | output | 1 | Instruction-fault trap pulse |
| trap_data | output | 1 | Data-fault trap pulse |
| grant_full | output | 1 | Suppressed fault: grant full-permission access |

## Verification
A corrupted status register shows on rd_data in the cycle after the faulting event: a wrong field position or a lost overflow marker appears in the first status read. A clear that fails, or one that wrongly beats a simultaneous fault, shows in the next read, one cycle later. A wrong outcome decision shows in the cycle right after the event as the wrong pulse, two pulses, or a pulse that lingers.

// File: rtl/fsac_pkg.sv
package fsac_pkg;
  // Field widths of the status word; positions are decoded by software.
  localparam int LVL_W  = 2;
  localparam int IDX_W  = 3;
  localparam int KIND_W = 3;
  localparam int STAT_W = LVL_W + IDX_W + KIND_W + 2;

  typedef struct packed {
    logic [LVL_W-1:0]  lvl;   // bits 9:8
    logic [IDX_W-1:0]  idx;   // bits 7:5
    logic [KIND_W-1:0] kind;  // bits 4:2
    logic              fav;   // bit 1: address register valid
    logic              ovf;   // bit 0: earlier fault lost
  } fstat_t;

  function automatic fstat_t make_fresh(input logic [LVL_W-1:0] lvl,
                                        input logic [IDX_W-1:0] idx,
                                        input logic [KIND_W-1:0] kind);
    fstat_t s;
    s.lvl  = lvl;
    s.idx  = idx;
    s.kind = kind;
    s.fav  = 1'b1;
    s.ovf  = 1'b0;
    return s;
  endfunction
endpackage

// File: rtl/fsac_status_reg.sv
module fsac_status_reg
  import fsac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cap,
  input  logic   clr,
  input  fstat_t fresh,
  output fstat_t stat_q
);
  fstat_t merged;
  logic   pending;

  // An unread earlier fault is kept only as the overflow marker.
  assign pending = (stat_q != '0) && !clr;

  always_comb begin
    merged     = fresh;
    merged.ovf = pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (cap) begin
      stat_q <= merged;
    end else if (clr) begin
      stat_q <= '0;
    end
  end
endmodule

// File: rtl/fsac_addr_reg.sv
module fsac_addr_reg #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic [VA_W-1:0] va,
  output logic [VA_W-1:0] addr_q
);
  logic [VA_W-1:0] aligned;

  generate
    if (PAGE_BITS > 0) begin : g_mask
      assign aligned = {va[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    end else begin : g_nomask
      assign aligned = va;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (cap) begin
      addr_q <= aligned;
    end
  end
endmodule

// File: rtl/fsac_trap_sel.sv
module fsac_trap_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic is_fetch,
  input  logic no_fault,
  input  logic traps_en,
  output logic trap_i,
  output logic trap_d,
  output logic grant
);
  logic suppress;
  assign suppress = no_fault || !traps_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_i <= 1'b0;
      trap_d <= 1'b0;
      grant  <= 1'b0;
    end else begin
      trap_i <= cap && !suppress && is_fetch;
      trap_d <= cap && !suppress && !is_fetch;
      grant  <= cap && suppress;
    end
  end
endmodule

// File: rtl/fault_capture_unit.sv
module fault_capture_unit
  import fsac_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic              flt_fetch,
  input  logic [LVL_W-1:0]  flt_level,
  input  logic [KIND_W-1:0] flt_kind,
  input  logic [IDX_W-1:0]  flt_acc_idx,
  input  logic [VA_W-1:0]   flt_vaddr,
  input  logic              ctl_no_fault,
  input  logic              ctl_traps_en,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [VA_W-1:0]   rd_data,
  output logic              trap_ifetch,
  output logic              trap_data,
  output logic              grant_full
);
  localparam int PAD_W = VA_W - STAT_W;

  fstat_t          stat_q;
  fstat_t          fresh;
  logic [VA_W-1:0] addr_q;
  logic            stat_rd;

  assign fresh   = make_fresh(flt_level, flt_acc_idx, flt_kind);
  assign stat_rd = rd_en && !rd_sel;

  fsac_status_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (flt_valid),
    .clr    (stat_rd),
    .fresh  (fresh),
    .stat_q (stat_q)
  );

  fsac_addr_reg #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (flt_valid),
    .va     (flt_vaddr),
    .addr_q (addr_q)
  );

  fsac_trap_sel u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (flt_valid),
    .is_fetch (flt_fetch),
    .no_fault (ctl_no_fault),
    .traps_en (ctl_traps_en),
    .trap_i   (trap_ifetch),
    .trap_d   (trap_data),
    .grant    (grant_full)
  );

  always_comb begin
    if (rd_sel) rd_data = addr_q;
    else        rd_data = {{PAD_W{1'b0}}, stat_q};
  end
endmodule

// File: rtl/fsac_checker.sv
module fsac_checker
  import fsac_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_valid,
  input logic              flt_fetch,
  input logic [LVL_W-1:0]  flt_level,
  input logic [KIND_W-1:0] flt_kind,
  input logic [IDX_W-1:0]  flt_acc_idx,
  input logic [VA_W-1:0]   flt_vaddr,
  input logic              ctl_no_fault,
  input logic              ctl_traps_en,
  input logic              rd_en,
  input logic              rd_sel,
  input logic [STAT_W-1:0] stat_q,
  input logic [VA_W-1:0]   addr_q,
  input logic              trap_ifetch,
  input logic              trap_data,
  input logic              grant_full
);
  logic [STAT_W-1:0] want;
  assign want = {flt_level, flt_acc_idx, flt_kind, 2'b10};

  p_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && stat_q == '0 |=> stat_q == $past(want));

  p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && stat_q != '0 && !(rd_en && !rd_sel) |=> stat_q == ($past(want) | 1));

  p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> addr_q[VA_W-1:PAGE_BITS] == $past(flt_vaddr[VA_W-1:PAGE_BITS])
                  && addr_q[PAGE_BITS-1:0] == '0);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_sel && !flt_valid |=> stat_q == '0);

  p_read_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_sel && flt_valid |=> stat_q == $past(want));

  p_addr_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_sel && !flt_valid |=> $stable(stat_q) && $stable(addr_q));

  p_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !ctl_no_fault && ctl_traps_en |=> (trap_ifetch == $past(flt_fetch))
                                                   && (trap_data == !$past(flt_fetch)));

  p_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && (ctl_no_fault || !ctl_traps_en) |=> grant_full && !trap_ifetch && !trap_data);

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ifetch, trap_data, grant_full}));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> !trap_ifetch && !trap_data && !grant_full);
endmodule

bind fault_capture_unit fsac_checker #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flt_valid    (flt_valid),
  .flt_fetch    (flt_fetch),
  .flt_level    (flt_level),
  .flt_kind     (flt_kind),
  .flt_acc_idx  (flt_acc_idx),
  .flt_vaddr    (flt_vaddr),
  .ctl_no_fault (ctl_no_fault),
  .ctl_traps_en (ctl_traps_en),
  .rd_en        (rd_en),
  .rd_sel       (rd_sel),
  .stat_q       (stat_q),
  .addr_q       (addr_q),
  .trap_ifetch  (trap_ifetch),
  .trap_data    (trap_data),
  .grant_full   (grant_full)
);

// File: tb/sim_fault_capture_unit.sv
`timescale 1ns/1ps
module sim_fault_capture_unit;
  localparam int VA_W = 32;
  localparam int PB   = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            flt_valid = 1'b0, flt_fetch = 1'b0;
  logic [1:0]      flt_level = '0;
  logic [2:0]      flt_kind = '0, flt_acc_idx = '0;
  logic [VA_W-1:0] flt_vaddr = '0;
  logic            ctl_no_fault = 1'b0, ctl_traps_en = 1'b1;
  logic            rd_en = 1'b0, rd_sel = 1'b0;
  logic [VA_W-1:0] rd_data;
  logic            trap_ifetch, trap_data, grant_full;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  fault_capture_unit #(.VA_W(VA_W), .PAGE_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_fetch(flt_fetch),
    .flt_level(flt_level), .flt_kind(flt_kind), .flt_acc_idx(flt_acc_idx),
    .flt_vaddr(flt_vaddr), .ctl_no_fault(ctl_no_fault), .ctl_traps_en(ctl_traps_en),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .trap_ifetch(trap_ifetch),
    .trap_data(trap_data), .grant_full(grant_full));

  task automatic check(input string req, input logic [VA_W-1:0] got, input logic [VA_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] fresh_of(input int lv, input int ix, input int kd);
    return VA_W'(lv * 256 + ix * 32 + kd * 4 + 2);
  endfunction

  // peek a register without side effects (rd_en low, combinational mux)
  task automatic peek(input logic sel, output logic [VA_W-1:0] v);
    rd_sel = sel; rd_en = 1'b0; #1; v = rd_data;
  endtask

  // one fault at this negedge; outputs checked at the next negedge
  task automatic fault(input int lv, input int ix, input int kd, input logic [VA_W-1:0] va,
                       input logic fetch, input logic rd_stat);
    flt_valid = 1'b1; flt_level = 2'(lv); flt_acc_idx = 3'(ix); flt_kind = 3'(kd);
    flt_vaddr = va; flt_fetch = fetch; rd_en = rd_stat; rd_sel = 1'b0;
    @(negedge clk);
    flt_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic read_status(input logic [VA_W-1:0] exp, input string req);
    rd_sel = 1'b0; rd_en = 1'b1; #1;
    check(req, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [VA_W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(1'b0, v); check("R1 status", v, '0);
    peek(1'b1, v); check("R1 address", v, '0);
    check("R1 pulses", {29'd0, trap_ifetch, trap_data, grant_full}, '0);

    // R2, R4, R5 sweep every field value from an empty status word
    for (int lv = 0; lv < 4; lv++)
      for (int ix = 0; ix < 8; ix++)
        for (int kd = 0; kd < 8; kd++) begin
          logic [VA_W-1:0] va;
          va = 32'h9E37_79B9 * (lv * 64 + ix * 8 + kd + 1);
          fault(lv, ix, kd, va, 1'b0, 1'b0);
          peek(1'b1, v); check("R4 aligned address", v, va & ~32'hFFF);
          read_status(fresh_of(lv, ix, kd), "R2 fresh status / R5 read value");
          peek(1'b0, v); check("R5 cleared after read", v, '0);
        end

    // R3 overflow: unread fault followed by another
    for (int k = 0; k < 16; k++) begin
      fault(k % 4, 7 - (k % 8), k % 8, 32'h1000 * k, 1'b0, 1'b0);
      fault((k + 1) % 4, k % 8, (k + 3) % 8, 32'h2345_6789, 1'b1, 1'b0);
      read_status(fresh_of((k + 1) % 4, k % 8, (k + 3) % 8) | 1, "R3 overflow merge");
    end
    // R3 with three stacked faults keeps only the last plus overflow
    fault(3, 7, 7, 32'hFFFF_FFFF, 1'b0, 1'b0);
    fault(1, 1, 1, 32'h0, 1'b0, 1'b0);
    fault(0, 0, 0, 32'h0000_1FFF, 1'b0, 1'b0);
    peek(1'b1, v); check("R4 last address", v, 32'h0000_1000);
    read_status(32'h3, "R3 triple fault");

    // R6 read of status coinciding with a fault
    fault(2, 5, 3, 32'hABCD_E123, 1'b0, 1'b0);
    rd_sel = 1'b0; rd_en = 1'b1; #1;
    check("R6 read value before race", rd_data, fresh_of(2, 5, 3));
    fault(1, 6, 4, 32'h1234_5678, 1'b0, 1'b1);
    peek(1'b0, v); check("R6 race captures fresh fault", v, fresh_of(1, 6, 4));
    read_status(fresh_of(1, 6, 4), "R6 second read");

    // R7 address read leaves both registers alone
    fault(3, 2, 6, 32'h7777_7777, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      rd_sel = 1'b1; rd_en = 1'b1; #1;
      check("R7 address read value", rd_data, 32'h7777_7000);
      @(negedge clk);
      rd_en = 1'b0;
    end
    peek(1'b1, v); check("R7 address unchanged", v, 32'h7777_7000);
    peek(1'b0, v); check("R7 status unchanged", v, fresh_of(3, 2, 6));
    read_status(fresh_of(3, 2, 6), "R7 status still readable");

    // R8, R9, R10 outcome sweep
    for (int c = 0; c < 8; c++) begin
      logic f, nf, te, sup;
      f = c[0]; nf = c[1]; te = c[2];
      sup = nf || !te;
      ctl_no_fault = nf; ctl_traps_en = te;
      fault(1, c, c, 32'h0, f, 1'b1);
      check(sup ? "R9 grant_full" : "R8 trap select",
            {29'd0, trap_ifetch, trap_data, grant_full},
            {29'd0, !sup && f, !sup && !f, sup});
      @(negedge clk);
      check("R10 pulse ends", {29'd0, trap_ifetch, trap_data, grant_full}, '0);
    end
    ctl_no_fault = 1'b0; ctl_traps_en = 1'b1;
    // R10 back-to-back faults give one pulse each cycle, then quiet
    fault(0, 2, 1, 32'h0, 1'b1, 1'b1);
    check("R10 first of pair", {29'd0, trap_ifetch, trap_data, grant_full}, 32'd4);
    fault(0, 2, 1, 32'h0, 1'b0, 1'b1);
    check("R10 second of pair", {29'd0, trap_ifetch, trap_data, grant_full}, 32'd2);
    @(negedge clk);
    check("R10 quiet", {29'd0, trap_ifetch, trap_data, grant_full}, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule